// File: doc/BRIEF.md
# Store-Conditional Reservation Monitor

This block tracks one load-reserve reservation for each hardware thread and decides whether that thread's conditional word store may commit. A load-reserve request records three things for the issuing thread: a valid flag, the 128-byte line address it targets and the width it reserved. A later conditional store from the same thread forms its effective address from two register operands and compares that address with the stored reservation. The block then reports pass or fail as a 4-bit condition field and, on a pass, raises one memory write strobe.

A snoop port reports stores made by other agents. Any reservation whose line matches a snooped store is dropped. A context-clear input removes a thread's reservation without any conflicting store, which allows spurious failure. Every conditional store uses up its thread's reservation, whether it commits or not. Results are registered and appear one cycle after the request.

Top module: `resv_monitor`

## Requirements
- R1: The effective address is the low 32 bits of base plus index, where the base is `ra_val`, or the constant zero when `ra_zero` is 1. The address of a store request appears on `wr_addr` one cycle later.
- R2: A conditional store (`req_valid`=1, `req_store`=1) passes only if its thread holds a valid word-width reservation and the reserved line equals bits 31:7 of the effective address. The outcome appears on the outputs exactly one cycle after the request, with `res_valid`=1.
- R3: On a pass, `wr_en`=1 and `wr_data` carries `rs_val[31:0]` in big-endian order: `wr_data[31:24]` is the byte at `wr_addr`. Bits 63:32 of `rs_val` have no effect.
- R4: On a failure, `wr_en`=0 and `wr_data`=0.
- R5: `res_cr` is {LT, GT, EQ, SO} from bit 3 down to bit 0. LT and GT are always 0. EQ is 1 exactly on a pass. SO equals `so_in` as sampled with the request.
- R6: Every conditional store clears its thread's reservation, pass or fail, so a second store with no new load-reserve fails.
- R7: A doubleword reservation (`req_dword`=1 on the load-reserve) never lets a conditional store pass.
- R8: A snoop (`snoop_valid`=1) to any byte of a reserved line clears the reservation of every thread holding that line. A snoop in the same cycle as a store to that line forces the store to fail.
- R9: A store whose effective address has bits 1:0 not equal to zero sets `align_fault`=1, does not write, reports EQ=0 and still clears the reservation.
- R10: `ctx_clr_valid` clears the reservation of thread `ctx_clr_tid`. When it arrives in the same cycle as that thread's store, the store fails.
- R11: A load-reserve replaces any earlier reservation of the same thread. Each thread's reservation is independent of the others.
- R12: After reset no thread holds a reservation and all outputs are 0. Cycles without a store request show `res_valid`=0 and `wr_en`=0.

Ports order: as listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = conditional store, 0 = load-reserve |
| req_dword | input | 1 | Load-reserve width: 1 = doubleword, 0 = word |
| req_tid | input | TID_W | Issuing thread |
| ra_zero | input | 1 | Base register field is zero, so base is constant 0 |
| ra_val | input | 64 | Base operand |
| rb_val | input | 64 | Index operand |
| rs_val | input | 64 | Store source operand |
| so_in | input | 1 | Summary-overflow bit |
| snoop_valid | input | 1 | Another agent stored this cycle |
| snoop_addr | input | 32 | Address of that store |
| ctx_clr_valid | input | 1 | Drop one thread's reservation |
| ctx_clr_tid | input | TID_W | Thread whose reservation is dropped |
| res_valid | output | 1 | Store result valid |
| res_cr | output | 4 | {LT, GT, EQ, SO} |
| align_fault | output | 1 | Store address misaligned |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 32 | Store effective address |
| wr_data | output | 32 | Big-endian store word |

## Verification
The reservation table can only be observed through the outcome of a later conditional store. A stale valid flag, a wrong line tag or a wrong width code shows up as a wrong EQ bit and a wrong `wr_en` on the first store that thread makes after the error. That is one cycle after the store request, and possibly many cycles after the fault itself. The bench keeps its own reservation model, keeps addresses within a small pool of lines so that hits, snoops and cross-thread aliasing happen often, and compares every output on every store.

// File: rtl/resv_monitor.sv
module resv_monitor #(
  parameter int THREADS   = 4,
  parameter int LINE_BITS = 7,
  parameter int TID_W     = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic             req_dword,
  input  logic [TID_W-1:0] req_tid,
  input  logic             ra_zero,
  input  logic [63:0]      ra_val,
  input  logic [63:0]      rb_val,
  input  logic [63:0]      rs_val,
  input  logic             so_in,
  input  logic             snoop_valid,
  input  logic [31:0]      snoop_addr,
  input  logic             ctx_clr_valid,
  input  logic [TID_W-1:0] ctx_clr_tid,
  output logic             res_valid,
  output logic [3:0]       res_cr,
  output logic             align_fault,
  output logic             wr_en,
  output logic [31:0]      wr_addr,
  output logic [31:0]      wr_data
);
  localparam int TAG_W = 32 - LINE_BITS;
  localparam logic [1:0] WID_NONE = 2'd0;
  localparam logic [1:0] WID_WORD = 2'd1;
  localparam logic [1:0] WID_DBL  = 2'd2;

  logic [THREADS-1:0] rv;
  logic [TAG_W-1:0]   rtag [THREADS];
  logic [1:0]         rwid [THREADS];

  logic [31:0]      ea;
  logic [TAG_W-1:0] ea_tag, snp_tag;
  logic             is_st, is_lr, misal, snp_kill, ctx_kill, pass;

  assign ea       = (ra_zero ? 32'd0 : ra_val[31:0]) + rb_val[31:0];
  assign ea_tag   = ea[31:LINE_BITS];
  assign snp_tag  = snoop_addr[31:LINE_BITS];
  assign is_st    = req_valid & req_store;
  assign is_lr    = req_valid & ~req_store;
  assign misal    = |ea[1:0];
  assign snp_kill = snoop_valid && (snp_tag == ea_tag);
  assign ctx_kill = ctx_clr_valid && (ctx_clr_tid == req_tid);
  assign pass     = is_st && rv[req_tid] && (rwid[req_tid] == WID_WORD) &&
                    (rtag[req_tid] == ea_tag) && !misal && !snp_kill && !ctx_kill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv <= '0;
      for (int i = 0; i < THREADS; i++) begin
        rtag[i] <= '0;
        rwid[i] <= WID_NONE;
      end
    end else begin
      for (int i = 0; i < THREADS; i++) begin
        if (snoop_valid && rv[i] && rtag[i] == snp_tag) begin
          rv[i]   <= 1'b0;
          rwid[i] <= WID_NONE;
        end
        if (ctx_clr_valid && ctx_clr_tid == TID_W'(i)) begin
          rv[i]   <= 1'b0;
          rwid[i] <= WID_NONE;
        end
        if (req_valid && req_tid == TID_W'(i)) begin
          if (req_store) begin
            rv[i]   <= 1'b0;
            rwid[i] <= WID_NONE;
          end else begin
            rv[i]   <= 1'b1;
            rtag[i] <= ea_tag;
            rwid[i] <= req_dword ? WID_DBL : WID_WORD;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_cr      <= '0;
      align_fault <= 1'b0;
      wr_en       <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
    end else begin
      res_valid   <= is_st;
      res_cr      <= {2'b00, pass, is_st & so_in};
      align_fault <= is_st & misal;
      wr_en       <= pass;
      wr_addr     <= is_st ? ea : 32'd0;
      wr_data     <= pass ? rs_val[31:0] : 32'd0;
    end
  end

  // R6
  store_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_st |=> !rv[$past(req_tid)]);
  // R9
  write_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!align_fault && wr_addr[1:0] == 2'b00));
  // R5
  cr_lt_gt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_cr[3:2] == 2'b00 && res_cr[0] == $past(so_in)));
  // R8
  snoop_forces_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_st && snoop_valid && snp_tag == ea_tag) |=> !wr_en);
  // R7
  dword_never_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_st && rwid[req_tid] == WID_DBL) |=> !wr_en);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_st |=> (!res_valid && !wr_en));
endmodule

// File: tb/tb_resv_monitor.sv
module tb_resv_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_store = 0, req_dword = 0, ra_zero = 0, so_in = 0;
  logic [1:0] req_tid = 0, ctx_clr_tid = 0;
  logic [63:0] ra_val = 0, rb_val = 0, rs_val = 0;
  logic snoop_valid = 0, ctx_clr_valid = 0;
  logic [31:0] snoop_addr = 0;
  logic res_valid, align_fault, wr_en;
  logic [3:0] res_cr;
  logic [31:0] wr_addr, wr_data;

  int n_tests = 0, n_fail = 0;
  bit mv[NT];
  bit [24:0] mtag[NT];
  bit mdw[NT];

  always #(CLK_PERIOD/2) clk = ~clk;

  resv_monitor #(.THREADS(NT)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_dword(req_dword), .req_tid(req_tid), .ra_zero(ra_zero), .ra_val(ra_val),
    .rb_val(rb_val), .rs_val(rs_val), .so_in(so_in), .snoop_valid(snoop_valid),
    .snoop_addr(snoop_addr), .ctx_clr_valid(ctx_clr_valid), .ctx_clr_tid(ctx_clr_tid),
    .res_valid(res_valid), .res_cr(res_cr), .align_fault(align_fault),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  task automatic check(input string tag, input logic [70:0] got, input logic [70:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic op(input bit st, input bit dw, input int tid, input bit raz,
                    input logic [63:0] ra, input logic [63:0] rb, input logic [63:0] rs,
                    input bit so, input bit sv, input logic [31:0] sa,
                    input bit cv, input int ct, input string tag);
    logic [31:0] ea;
    bit mis, pass;
    @(negedge clk);
    req_valid = 1; req_store = st; req_dword = dw; req_tid = tid[1:0];
    ra_zero = raz; ra_val = ra; rb_val = rb; rs_val = rs; so_in = so;
    snoop_valid = sv; snoop_addr = sa; ctx_clr_valid = cv; ctx_clr_tid = ct[1:0];
    ea = (raz ? 32'd0 : ra[31:0]) + rb[31:0];
    mis = (ea[1:0] != 2'b00);
    pass = st && mv[tid] && !mdw[tid] && mtag[tid] == ea[31:7] && !mis &&
           !(sv && sa[31:7] == ea[31:7]) && !(cv && ct == tid);
    for (int i = 0; i < NT; i++) begin
      if (sv && mv[i] && mtag[i] == sa[31:7]) mv[i] = 0;
      if (cv && ct == i) mv[i] = 0;
    end
    if (st) mv[tid] = 0;
    else begin mv[tid] = 1; mtag[tid] = ea[31:7]; mdw[tid] = dw; end
    @(negedge clk);
    check(tag, {res_valid, res_cr, align_fault, wr_en, wr_addr, wr_data},
          {st, 2'b00, pass, st & so, st & mis, pass, st ? ea : 32'd0,
           pass ? rs[31:0] : 32'd0});
    req_valid = 0; snoop_valid = 0; ctx_clr_valid = 0;
  endtask

  task automatic lr(input int tid, input logic [31:0] a, input bit dw, input string tag);
    op(0, dw, tid, 1, 64'hFFFF_0000_DEAD_0000, {32'h0, a}, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic sc(input int tid, input logic [31:0] a, input logic [63:0] rs,
                    input bit so, input string tag);
    op(1, 0, tid, 1, 0, {32'hA5A5_0000, a}, rs, so, 0, 0, 0, 0, tag);
  endtask

  localparam logic [31:0] LA = 32'h1000_0080;
  localparam logic [31:0] LB = 32'h1000_0100;

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check("R12", {res_valid, res_cr, align_fault, wr_en, wr_addr, wr_data}, '0);
    sc(0, LA, 64'h1, 0, "R12");
    // R2 R3 pass, upper rs ignored, so propagated
    lr(0, LA, 0, "R2");
    sc(0, LA + 4, 64'hFFFF_FFFF_1234_5678, 1, "R3");
    // R6 second store fails
    sc(0, LA + 4, 64'h55, 0, "R6");
    // R7 doubleword reservation
    lr(1, LA, 1, "R7");
    sc(1, LA, 64'h77, 0, "R7");
    // R8 snoop in a separate cycle, different byte same line
    lr(2, LA, 0, "R8");
    lr(3, LA, 0, "R8");
    op(0, 0, 0, 1, 0, {32'h0, LB}, 0, 0, 1, LA + 32'h7C, 0, 0, "R8");
    sc(2, LA, 64'h9, 0, "R8");
    sc(3, LA, 64'h9, 0, "R8");
    // R8 same-cycle snoop
    lr(2, LB, 0, "R8");
    op(1, 0, 2, 1, 0, {32'h0, LB}, 64'h3, 0, 1, LB + 5, 0, 0, "R8");
    // R9 misaligned, then reservation gone
    lr(1, LA, 0, "R9");
    sc(1, LA + 2, 64'h4, 0, "R9");
    sc(1, LA, 64'h4, 0, "R9");
    // R10 context clear separate and same cycle
    lr(3, LB, 0, "R10");
    op(0, 0, 0, 1, 0, {32'h0, LA}, 0, 0, 0, 0, 1, 3, "R10");
    sc(3, LB, 64'h6, 0, "R10");
    lr(3, LB, 0, "R10");
    op(1, 0, 3, 1, 0, {32'h0, LB}, 64'h6, 0, 0, 0, 1, 3, "R10");
    // R1 base register used, and base-zero with nonzero ra
    lr(0, LB, 0, "R1");
    op(1, 0, 0, 0, 64'h7777_0000_1000_0000, 64'h0000_0000_0000_0108, 64'hCAFE, 0, 0, 0, 0, 0, "R1");
    lr(0, LB, 0, "R1");
    op(1, 0, 0, 1, 64'h0000_0000_0000_0040, {32'h0, LB + 8}, 64'hBEEF, 0, 0, 0, 0, 0, "R1");
    // R11 replace, and independence
    lr(1, LA, 0, "R11");
    lr(1, LB, 0, "R11");
    lr(2, LA, 0, "R11");
    sc(1, LA, 64'h11, 0, "R11");
    sc(2, LA, 64'h22, 0, "R11");
    // R4 random mix
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] a, s, off;
      logic [63:0] ra;
      bit raz;
      off = $urandom % 128;
      if ($urandom % 10 != 0) off = off & 32'hFFFF_FFFC;
      a = 32'h2000_0000 + (($urandom % 4) << 7) + off;
      s = 32'h2000_0000 + (($urandom % 4) << 7) + ($urandom % 128);
      raz = ($urandom % 5 == 0);
      ra = {$urandom, $urandom};
      op($urandom % 2, $urandom % 4 == 0, $urandom % NT, raz, ra,
         {$urandom, raz ? a : a - ra[31:0]}, {$urandom, $urandom}, $urandom % 2,
         $urandom % 7 == 0, s, $urandom % 10 == 0, $urandom % NT, "R4");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule